// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Unit

This block merges the interrupt sources of a 16550-style serial controller into one interrupt request line and one identification byte. Five sources compete: receiver line errors, the character timeout, received data, transmitter holding empty and modem status changes. Each source is qualified by its bit of the enable register. The highest-priority qualified source decides the 4-bit code in the low nibble of the identification byte. The upper two bits of the byte report whether the FIFOs are enabled.

The block keeps one piece of hidden state: a transmitter-empty pending flag. The flag is raised when the holding register becomes empty, or when software writes the enable register while the holding register is empty. A read of the identification register drops the flag, and so does the holding register filling up. The serializer, the FIFOs and the bus decoder sit outside the block. They feed it status levels and one-cycle strobes.

The identification byte and the interrupt line are both registered. Each reflects the inputs of the previous cycle. A read strobe is therefore served the byte as it stood before that read cleared anything.

Top module: `uart_int_ident`

## Requirements
- R1: Synchronous reset forces the identification byte to 0x01, drives the interrupt line low and clears the pending flag. Strobes given during reset have no effect.
- R2: When several qualified sources are active, the code follows this order, highest first: line status (0x6), timeout (0xC), received data (0x4), transmitter empty (0x2), modem status (0x0). The code 0x1 means that no source is active.
- R3: A line status interrupt (code 0x6) needs enable bit 2 and at least one of status bits 1 to 4 (overrun, parity, framing, break). Status bit 0 (data ready) does not raise it.
- R4: The timeout interrupt (code 0xC) needs the timeout flag and enable bit 0. No other enable bit releases it.
- R5: A received-data interrupt (code 0x4) needs enable bit 0 and status bit 0. With FIFOs off that is enough. With FIFOs on, the receive count must also be at or above the trigger level.
- R6: The pending flag is set in the cycle after status bit 5 (holding empty) rises. With enable bit 1, code 0x2 appears one cycle after that.
- R7: An identification read strobe clears the pending flag. The byte present in the read cycle still shows the code from before the clear.
- R8: An enable-write strobe sets the pending flag only while status bit 5 is high. While status bit 5 is low, the flag is held clear and the write has no effect.
- R9: A modem status interrupt (code 0x0) needs enable bit 3 and any of the four delta bits.
- R10: Bits 7:6 of the byte read 2'b11 when the FIFO-enable input is high and 2'b00 otherwise. Bits 5:4 always read zero.
- R11: The interrupt line is high exactly when the low nibble of the byte is not 0x1. Both outputs reflect the inputs of the previous cycle.
- R12: If a read strobe and a set event (an enable write, or a rise of status bit 5) occur in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enableReg | input | 4 | Interrupt enables: bit0 received data/timeout, bit1 transmitter empty, bit2 line status, bit3 modem status |
| lineStatus | input | 8 | Line status: bit0 data ready, bits1-4 overrun/parity/framing/break, bit5 holding empty |
| rxTimeout | input | 1 | Character timeout flag |
| rxCount | input | CNT_W | Receive FIFO fill count |
| rxTrigger | input | CNT_W | Receive FIFO trigger level |
| fifoOn | input | 1 | FIFO mode enabled |
| modemDelta | input | 4 | Modem status delta bits |
| identRead | input | 1 | Strobe: identification register read |
| enableWrite | input | 1 | Strobe: enable register write |
| identByte | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
The pending flag can be cleared by an identification read and set by an enable write, or by a rise of the holding-empty bit, in the same cycle. The bench provokes the collision by asserting both strobes together while the transmitter code is showing. It then expects code 0x2 to persist in the following cycles, because the set wins. Separate steps pulse each strobe alone, so the result of the collision can be told apart from a flag that never changed.

// File: rtl/uart_int_pkg.sv
`timescale 1ns/1ps
package uart_int_pkg;

  // Low-nibble identification codes; the values are decoded by software.
  typedef enum logic [3:0] {
    SRC_MODEM   = 4'h0,
    SRC_NONE    = 4'h1,
    SRC_TXEMPTY = 4'h2,
    SRC_RXDATA  = 4'h4,
    SRC_LINE    = 4'h6,
    SRC_TIMEOUT = 4'hC
  } intSrc_e;

  // Enable register bit positions
  localparam int EN_RXDATA  = 0;
  localparam int EN_TXEMPTY = 1;
  localparam int EN_LINE    = 2;
  localparam int EN_MODEM   = 3;

  // Line status bit positions
  localparam int LS_READY      = 0;
  localparam int LS_ERR_LO     = 1;
  localparam int LS_ERR_HI     = 4;
  localparam int LS_HOLD_EMPTY = 5;

  // Control-to-datapath strobes
  typedef struct packed {
    logic txPending;
  } ctlStrobe_t;

endpackage

// File: rtl/uart_int_ctl.sv
`timescale 1ns/1ps
module uart_int_ctl
  import uart_int_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       holdEmpty,
  input  logic       identRead,
  input  logic       enableWrite,
  output ctlStrobe_t ctl
);

  logic pendQ;
  logic holdQ;
  logic setEvent;

  // A new empty condition or an enable write re-arms the flag.
  assign setEvent = (holdEmpty && !holdQ) || enableWrite;

  always_ff @(posedge clk) begin
    if (rst) begin
      pendQ <= 1'b0;
      holdQ <= 1'b1;  // no spurious edge if the holding register is empty out of reset
    end else begin
      holdQ <= holdEmpty;
      if (!holdEmpty)      pendQ <= 1'b0;
      else if (setEvent)   pendQ <= 1'b1;  // set beats a same-cycle read (R12)
      else if (identRead)  pendQ <= 1'b0;
    end
  end

  assign ctl.txPending = pendQ;

endmodule

// File: rtl/uart_int_dp.sv
`timescale 1ns/1ps
module uart_int_dp
  import uart_int_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       enableReg,
  input  logic [7:0]       lineStatus,
  input  logic             rxTimeout,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] rxTrigger,
  input  logic             fifoOn,
  input  logic [3:0]       modemDelta,
  input  ctlStrobe_t       ctl,
  output logic [7:0]       identByte,
  output logic             irq
);

  localparam int ERR_W = LS_ERR_HI - LS_ERR_LO + 1;

  logic [ERR_W-1:0] errBits;
  logic lineHit, toHit, rdHit, txHit, mdHit, levelOk;
  intSrc_e code;
  logic [7:0] identQ;
  logic irqQ;

  assign errBits = lineStatus[LS_ERR_HI:LS_ERR_LO];
  assign levelOk = !fifoOn || (rxCount >= rxTrigger);
  assign lineHit = enableReg[EN_LINE] && (|errBits);
  assign toHit   = enableReg[EN_RXDATA] && rxTimeout;
  assign rdHit   = enableReg[EN_RXDATA] && lineStatus[LS_READY] && levelOk;
  assign txHit   = enableReg[EN_TXEMPTY] && ctl.txPending;
  assign mdHit   = enableReg[EN_MODEM] && (|modemDelta);

  always_comb begin
    if (lineHit)     code = SRC_LINE;
    else if (toHit)  code = SRC_TIMEOUT;
    else if (rdHit)  code = SRC_RXDATA;
    else if (txHit)  code = SRC_TXEMPTY;
    else if (mdHit)  code = SRC_MODEM;
    else             code = SRC_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      identQ <= {4'h0, SRC_NONE};
      irqQ   <= 1'b0;
    end else begin
      identQ <= {fifoOn, fifoOn, 2'b00, code};
      irqQ   <= (code != SRC_NONE);
    end
  end

  assign identByte = identQ;
  assign irq       = irqQ;

endmodule

// File: rtl/uart_int_ident.sv
`timescale 1ns/1ps
module uart_int_ident
  import uart_int_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       enableReg,
  input  logic [7:0]       lineStatus,
  input  logic             rxTimeout,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] rxTrigger,
  input  logic             fifoOn,
  input  logic [3:0]       modemDelta,
  input  logic             identRead,
  input  logic             enableWrite,
  output logic [7:0]       identByte,
  output logic             irq
);

  ctlStrobe_t ctl;

  uart_int_ctl u_ctl (
    .clk         (clk),
    .rst         (rst),
    .holdEmpty   (lineStatus[LS_HOLD_EMPTY]),
    .identRead   (identRead),
    .enableWrite (enableWrite),
    .ctl         (ctl)
  );

  uart_int_dp #(.CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .enableReg  (enableReg),
    .lineStatus (lineStatus),
    .rxTimeout  (rxTimeout),
    .rxCount    (rxCount),
    .rxTrigger  (rxTrigger),
    .fifoOn     (fifoOn),
    .modemDelta (modemDelta),
    .ctl        (ctl),
    .identByte  (identByte),
    .irq        (irq)
  );

endmodule

// File: rtl/uart_int_ident_chk.sv
`timescale 1ns/1ps
module uart_int_ident_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] enableReg,
  input logic [7:0] lineStatus,
  input logic       fifoOn,
  input logic [7:0] identByte,
  input logic       irq
);

  // R11: the line and the code agree
  a_r11_irq_code: assert property (@(posedge clk) disable iff (rst)
    irq == (identByte[3:0] != 4'h1));

  // R2: only defined codes appear
  a_r2_code_legal: assert property (@(posedge clk) disable iff (rst)
    identByte[3:0] inside {4'h0, 4'h1, 4'h2, 4'h4, 4'h6, 4'hC});

  // R10: upper bits follow the previous cycle's FIFO mode
  a_r10_fifo_bits: assert property (@(posedge clk) disable iff (rst)
    (identByte[7:6] == {2{$past(fifoOn)}}) && (identByte[5:4] == 2'b00));

  // R3: an enabled error bit wins the next cycle
  a_r3_line_first: assert property (@(posedge clk) disable iff (rst)
    (enableReg[2] && (|lineStatus[4:1])) |=> (identByte[3:0] == 4'h6));

  // R4: timeout never shows without enable bit 0
  a_r4_timeout_gate: assert property (@(posedge clk) disable iff (rst)
    !enableReg[0] |=> (identByte[3:0] != 4'hC));

  // R8: a non-empty holding register keeps the transmitter code away two cycles later
  a_r8_full_blocks: assert property (@(posedge clk) disable iff (rst)
    $past(!lineStatus[5], 2) |-> (identByte[3:0] != 4'h2));

endmodule

bind uart_int_ident uart_int_ident_chk u_chk (.*);

// File: tb/sim_uart_int_ident.sv
`timescale 1ns/1ps
module sim_uart_int_ident;

  localparam int CNT_W = 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [3:0]       enableReg = '0;
  logic [7:0]       lineStatus = '0;
  logic             rxTimeout = 1'b0;
  logic [CNT_W-1:0] rxCount = '0;
  logic [CNT_W-1:0] rxTrigger = '0;
  logic             fifoOn = 1'b0;
  logic [3:0]       modemDelta = '0;
  logic             identRead = 1'b0;
  logic             enableWrite = 1'b0;
  logic [7:0]       identByte;
  logic             irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference state of the pending flag
  bit mFlag = 1'b0;
  bit mPrev = 1'b1;

  typedef struct {
    logic [7:0] b;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  uart_int_ident #(.CNT_W(CNT_W)) u0 (.*);

  function automatic logic [7:0] refByte(
    input logic [3:0] ie, input logic [7:0] ls, input logic to,
    input int cnt, input int trg, input logic fo, input logic [3:0] md, input bit flg);
    logic [3:0] c;
    if (ie[2] && (ls[1] || ls[2] || ls[3] || ls[4]))          c = 4'h6;
    else if (ie[0] && to)                                     c = 4'hC;
    else if (ie[0] && ls[0] && (!fo || cnt >= trg))           c = 4'h4;
    else if (ie[1] && flg)                                    c = 4'h2;
    else if (ie[3] && md != 4'h0)                             c = 4'h0;
    else                                                      c = 4'h1;
    return {fo, fo, 2'b00, c};
  endfunction

  task automatic step(
    input logic [3:0] ie, input logic [7:0] ls, input logic to,
    input int cnt, input int trg, input logic fo, input logic [3:0] md,
    input logic rd, input logic ew, input string tag);
    exp_t e;
    @(negedge clk);
    enableReg = ie; lineStatus = ls; rxTimeout = to;
    rxCount = CNT_W'(cnt); rxTrigger = CNT_W'(trg);
    fifoOn = fo; modemDelta = md; identRead = rd; enableWrite = ew;
    e.b = refByte(ie, ls, to, cnt, trg, fo, md, mFlag);
    e.tag = tag;
    q.push_back(e);
    if (!ls[5])                   mFlag = 1'b0;
    else if (!mPrev || ew)        mFlag = 1'b1;
    else if (rd)                  mFlag = 1'b0;
    mPrev = ls[5];
  endtask

  // Monitor: compare one expected item per cycle after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (identByte !== e.b || irq !== (e.b[3:0] != 4'h1)) begin
          errors++;
          $display("FAIL %s: identByte=%02h irq=%b expected identByte=%02h irq=%b",
                   e.tag, identByte, irq, e.b, (e.b[3:0] != 4'h1));
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset with active-looking inputs and strobes
    enableReg = 4'hF; lineStatus = 8'h10; enableWrite = 1'b1; identRead = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (identByte !== 8'h01 || irq !== 1'b0) begin
      errors++;
      $display("FAIL R1: identByte=%02h irq=%b expected identByte=01 irq=0", identByte, irq);
    end
    enableReg = 4'h0; lineStatus = 8'h00; enableWrite = 1'b0; identRead = 1'b0;
    rst = 1'b0;
    mFlag = 1'b0; mPrev = 1'b0;  // quiet cycle after release leaves holding bit low

    step(4'h0, 8'h00, 0, 0, 0, 0, 4'h0, 0, 0, "R11");  // nothing pending
    step(4'h0, 8'h00, 0, 0, 0, 1, 4'h0, 0, 0, "R10");  // fifo bits
    step(4'h4, 8'h10, 0, 0, 0, 0, 4'h0, 0, 0, "R3");   // break error
    step(4'h4, 8'h01, 0, 0, 0, 0, 4'h0, 0, 0, "R3");   // ready alone not an error
    step(4'h0, 8'h02, 0, 0, 0, 0, 4'h0, 0, 0, "R3");   // error but not enabled
    step(4'h1, 8'h00, 1, 0, 0, 0, 4'h0, 0, 0, "R4");   // timeout enabled
    step(4'hE, 8'h00, 1, 0, 0, 0, 4'h0, 0, 0, "R4");   // timeout masked
    step(4'h1, 8'h01, 0, 0, 0, 0, 4'h0, 0, 0, "R5");   // non-fifo data ready
    step(4'h1, 8'h01, 0, 3, 4, 1, 4'h0, 0, 0, "R5");   // below trigger
    step(4'h1, 8'h01, 0, 4, 4, 1, 4'h0, 0, 0, "R5");   // at trigger
    step(4'h8, 8'h00, 0, 0, 0, 0, 4'h4, 0, 0, "R9");   // modem delta
    step(4'hF, 8'h03, 1, 0, 0, 0, 4'h1, 0, 0, "R2");   // line wins
    step(4'hF, 8'h01, 1, 0, 0, 0, 4'h1, 0, 0, "R2");   // timeout next
    step(4'hF, 8'h01, 0, 0, 0, 0, 4'h1, 0, 0, "R2");   // data next
    step(4'hF, 8'h20, 0, 0, 0, 0, 4'h1, 0, 0, "R6");   // holding empty rises
    step(4'hF, 8'h20, 0, 0, 0, 0, 4'h1, 0, 0, "R2");   // tx beats modem
    step(4'hF, 8'h20, 0, 0, 0, 0, 4'h1, 1, 0, "R7");   // read sees pre-clear code
    step(4'hF, 8'h20, 0, 0, 0, 0, 4'h1, 0, 0, "R7");   // cleared: modem shows
    step(4'h2, 8'h20, 0, 0, 0, 0, 4'h0, 0, 0, "R7");
    step(4'h2, 8'h20, 0, 0, 0, 0, 4'h0, 0, 1, "R8");   // enable write while empty
    step(4'h2, 8'h20, 0, 0, 0, 0, 4'h0, 0, 0, "R8");
    step(4'h2, 8'h20, 0, 0, 0, 0, 4'h0, 1, 1, "R12");  // read and write together
    step(4'h2, 8'h20, 0, 0, 0, 0, 4'h0, 0, 0, "R12");
    step(4'h2, 8'h20, 0, 0, 0, 0, 4'h0, 0, 0, "R12");
    step(4'h2, 8'h20, 0, 0, 0, 0, 4'h0, 1, 0, "R7");
    step(4'h2, 8'h20, 0, 0, 0, 0, 4'h0, 0, 0, "R7");
    step(4'h2, 8'h00, 0, 0, 0, 0, 4'h0, 0, 1, "R8");   // write while holding full
    step(4'h2, 8'h00, 0, 0, 0, 0, 4'h0, 0, 0, "R8");
    step(4'h2, 8'h00, 0, 0, 0, 0, 4'h0, 0, 0, "R8");
    step(4'h2, 8'h20, 0, 0, 0, 0, 4'h0, 1, 0, "R12");  // rise and read together
    step(4'h2, 8'h20, 0, 0, 0, 0, 4'h0, 0, 0, "R12");
    step(4'h2, 8'h00, 0, 0, 0, 0, 4'h0, 0, 0, "R8");   // holding fills
    step(4'h2, 8'h00, 0, 0, 0, 0, 4'h0, 0, 0, "R8");
    step(4'h0, 8'h00, 0, 0, 0, 1, 4'h0, 0, 0, "R11");

    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule